// File: doc/BRIEF.md
# Interrupt Pending State Register Bank

This block keeps the pending, enable and active state for a set of interrupt lines (32 by default) and makes them visible to software through a small synchronous register port. Software sets pending bits through one word-wide alias and clears them through another. Reading either alias returns the same pending vector. Hardware request pulses also mark lines pending. A pending bit is recorded whether or not the line is enabled. The enable mask has its own set and clear aliases. The active flags can be read through a read-only word.

The consumer of this state, such as a priority arbiter or an exception sequencer, watches the `pending_o`, `enable_o` and `active_o` vectors. It reports its progress back through a per-line acknowledge (taken into service) and a per-line done (service finished). The register port has no handshake. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of the address and the current state. None of the interfaces carries a data stream, so the block has no valid/ready signalling and applies no back-pressure.

Top module: `irq_pend_bank`

## Requirements
- R1: After reset the pending, enable and active vectors are all zero, and every mapped word reads zero.
- R2: A write to byte offset 0x100 makes pending every line whose write-data bit is 1. Bits written 0 leave their lines unchanged, and a line that is already pending stays pending.
- R3: A write to byte offset 0x180 removes the pending state of every line whose write-data bit is 1. Bits written 0 leave their lines unchanged.
- R4: A read of offset 0x100 or 0x180 returns the current pending vector, with bit i set exactly when line i is pending.
- R5: A line becomes pending through a software set or a hardware request even while its enable bit is 0.
- R6: A request on `irq_req[i]` makes line i pending on the next edge. The request takes priority over a software clear or an acknowledge of the same line in the same cycle.
- R7: A software clear of a pending bit leaves that line's active flag unchanged.
- R8: `irq_ack[i]` clears line i's pending bit and sets its active flag. `irq_done[i]` clears the active flag. If both arrive for one line in the same cycle, the acknowledge takes priority and the flag is set.
- R9: A write to offset 0x000 sets the enable bits written as 1. A write to offset 0x080 clears the enable bits written as 1. Both offsets read back the enable vector.
- R10: Offset 0x200 reads the active vector, and writes to it change no state.
- R11: Reads of any other word offset return zero, and writes to such offsets change no state. Address bits [1:0] are ignored when decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | input | 32 | Hardware request pulses, one per line |
| irq_ack | input | 32 | Line taken into service |
| irq_done | input | 32 | Line service finished |
| pending_o | output | 32 | Current pending vector |
| enable_o | output | 32 | Current enable vector |
| active_o | output | 32 | Current active vector |

## Verification
Several sources can act on the same pending bit in one cycle. The main case is a hardware request that lands together with a software clear or an acknowledge of the same line. A second case is an acknowledge that lands together with a done on the active flag. Directed cycles set up each collision on purpose on a single line. A long random phase then drives sparse requests, acknowledges and dones underneath random register writes, so that collisions also occur on many lines at once. After every edge, all three state vectors and the read data are compared against a bench model that applies the stated priorities: the request wins over a clear, and the acknowledge wins over a done.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Which register word an access falls on
  typedef enum logic [2:0] {
    RG_NONE,
    RG_EN_SET,
    RG_EN_CLR,
    RG_PD_SET,
    RG_PD_CLR,
    RG_ACT
  } reg_sel_e;

  // Write strobes derived from a decoded write
  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic pd_set;
    logic pd_clr;
  } wr_strb_t;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] EN_SET_OFS = 'h000,
  parameter logic [ADDR_W-1:0] EN_CLR_OFS = 'h080,
  parameter logic [ADDR_W-1:0] PD_SET_OFS = 'h100,
  parameter logic [ADDR_W-1:0] PD_CLR_OFS = 'h180,
  parameter logic [ADDR_W-1:0] ACT_OFS    = 'h200
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output wr_strb_t          strb
);

  // Byte lanes inside a word take no part in the decode
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(3));

  logic [ADDR_W-1:0] word_addr;
  assign word_addr = addr & ALIGN_MASK;

  always_comb begin
    if (word_addr == (EN_SET_OFS & ALIGN_MASK))      sel = RG_EN_SET;
    else if (word_addr == (EN_CLR_OFS & ALIGN_MASK)) sel = RG_EN_CLR;
    else if (word_addr == (PD_SET_OFS & ALIGN_MASK)) sel = RG_PD_SET;
    else if (word_addr == (PD_CLR_OFS & ALIGN_MASK)) sel = RG_PD_CLR;
    else if (word_addr == (ACT_OFS & ALIGN_MASK))    sel = RG_ACT;
    else                                             sel = RG_NONE;
  end

  always_comb begin
    strb = '0;
    if (wr) begin
      case (sel)
        RG_EN_SET: strb.en_set = 1'b1;
        RG_EN_CLR: strb.en_clr = 1'b1;
        RG_PD_SET: strb.pd_set = 1'b1;
        RG_PD_CLR: strb.pd_clr = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pd,
  input  logic clr_pd,
  input  logic req,
  input  logic ack,
  input  logic done,
  input  logic set_en,
  input  logic clr_en,
  output logic pend,
  output logic act,
  output logic en
);

  // Pending: set sources win over clear sources
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pend <= 1'b0;
    else if (req || set_pd)   pend <= 1'b1;
    else if (clr_pd || ack)   pend <= 1'b0;
  end

  // Active: acknowledge wins over completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act <= 1'b0;
    else if (ack)   act <= 1'b1;
    else if (done)  act <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= 1'b0;
    else if (set_en)  en <= 1'b1;
    else if (clr_en)  en <= 1'b0;
  end

  // R6: request wins over clear and acknowledge
  a_r6_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> pend);

  // R2: software set lands
  a_r2_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_pd |=> pend);

  // R3: software clear lands when nothing sets
  a_r3_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pd && !req && !set_pd) |=> !pend);

  // R5: disabled line still latches a request
  a_r5_disabled_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && (req || set_pd)) |=> pend);

  // R7: software clear does not touch the active flag
  a_r7_clear_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pd && !ack && !done) |=> (act == $past(act)));

  // R8: acknowledge sets active, done alone clears it
  a_r8_ack_active: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> act);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ack) |=> !act);

  // R9: enable follows its strobes
  a_r9_en_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> en);

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32
) (
  input  reg_sel_e           sel,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] act,
  output logic [DATA_W-1:0]  rdata
);

  always_comb begin
    case (sel)
      RG_EN_SET, RG_EN_CLR: rdata = DATA_W'(en);
      RG_PD_SET, RG_PD_CLR: rdata = DATA_W'(pend);
      RG_ACT:               rdata = DATA_W'(act);
      default:              rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] EN_SET_OFS = 'h000,
  parameter logic [ADDR_W-1:0] EN_CLR_OFS = 'h080,
  parameter logic [ADDR_W-1:0] PD_SET_OFS = 'h100,
  parameter logic [ADDR_W-1:0] PD_CLR_OFS = 'h180,
  parameter logic [ADDR_W-1:0] ACT_OFS    = 'h200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_ack,
  input  logic [NUM_IRQ-1:0] irq_done,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] active_o
);

  reg_sel_e sel;
  wr_strb_t strb;

  irq_addr_dec #(
    .ADDR_W    (ADDR_W),
    .EN_SET_OFS(EN_SET_OFS),
    .EN_CLR_OFS(EN_CLR_OFS),
    .PD_SET_OFS(PD_SET_OFS),
    .PD_CLR_OFS(PD_CLR_OFS),
    .ACT_OFS   (ACT_OFS)
  ) u_dec (
    .addr(bus_addr),
    .wr  (bus_wr),
    .sel (sel),
    .strb(strb)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    irq_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .set_pd(strb.pd_set & bus_wdata[i]),
      .clr_pd(strb.pd_clr & bus_wdata[i]),
      .req   (irq_req[i]),
      .ack   (irq_ack[i]),
      .done  (irq_done[i]),
      .set_en(strb.en_set & bus_wdata[i]),
      .clr_en(strb.en_clr & bus_wdata[i]),
      .pend  (pending_o[i]),
      .act   (active_o[i]),
      .en    (enable_o[i])
    );
  end

  irq_read_mux #(
    .NUM_IRQ(NUM_IRQ),
    .DATA_W (DATA_W)
  ) u_rmux (
    .sel  (sel),
    .pend (pending_o),
    .en   (enable_o),
    .act  (active_o),
    .rdata(bus_rdata)
  );

  // R11: unmapped words read zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == RG_NONE) |-> (bus_rdata == '0));

  // R11: unmapped writes leave all state alone when no line input moves
  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == RG_NONE && irq_req == '0 && irq_ack == '0 && irq_done == '0)
      |=> ($stable(pending_o) && $stable(enable_o) && $stable(active_o)));

  // R10: writes to the active word change nothing
  a_r10_active_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == RG_ACT && irq_req == '0 && irq_ack == '0 && irq_done == '0)
      |=> ($stable(pending_o) && $stable(enable_o) && $stable(active_o)));

  // R4: the pending aliases read the pending vector
  a_r4_pend_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == RG_PD_SET || sel == RG_PD_CLR) |-> (bus_rdata == DATA_W'(pending_o)));

endmodule

// File: tb/tb_irq_pend_bank.sv
module tb_irq_pend_bank;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_req = '0;
  logic [N-1:0]  irq_ack = '0;
  logic [N-1:0]  irq_done = '0;
  logic [N-1:0]  pending_o, enable_o, active_o;

  irq_pend_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_ack(irq_ack), .irq_done(irq_done), .pending_o(pending_o),
    .enable_o(enable_o), .active_o(active_o)
  );

  always #5ns clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] m_pend = '0, m_en = '0, m_act = '0;

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [11:0] w;
    w = a & 12'hFFC;
    case (w)
      12'h000, 12'h080: return m_en;
      12'h100, 12'h180: return m_pend;
      12'h200:          return m_act;
      default:          return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // Model update for one edge, using the inputs now held
  task automatic model_step();
    logic [31:0] w;
    logic [31:0] sp, cp, se, ce;
    w  = {20'h0, bus_addr & 12'hFFC};
    sp = (bus_wr && w == 32'h100) ? bus_wdata : 32'h0;
    cp = (bus_wr && w == 32'h180) ? bus_wdata : 32'h0;
    se = (bus_wr && w == 32'h000) ? bus_wdata : 32'h0;
    ce = (bus_wr && w == 32'h080) ? bus_wdata : 32'h0;
    m_pend = (m_pend & ~cp & ~irq_ack) | sp | irq_req;
    m_act  = (m_act & ~irq_done) | irq_ack;
    m_en   = (m_en & ~ce) | se;
  endtask

  // Called at a negedge with inputs driven; checks after the next edge
  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, "pending", pending_o, m_pend);
    check(tag, "active", active_o, m_act);
    check(tag, "enable", enable_o, m_en);
    check(tag, "rdata", bus_rdata, model_read(bus_addr));
  endtask

  task automatic drive(logic wr, logic [11:0] a, logic [31:0] d,
                       logic [31:0] rq, logic [31:0] ak, logic [31:0] dn);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    irq_req = rq; irq_ack = ak; irq_done = dn;
  endtask

  task automatic peek(string tag, logic [11:0] a);
    drive(1'b0, a, 32'h0, '0, '0, '0);
    #1ns;
    check(tag, "read", bus_rdata, model_read(a));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned s;
    s = $urandom(32'd20240611);
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "pending", pending_o, 32'h0);
    check("R1", "active", active_o, 32'h0);
    check("R1", "enable", enable_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    peek("R1", 12'h100);
    peek("R1", 12'h000);
    peek("R1", 12'h200);

    // R2: set alias, zeros have no effect, repeat set keeps bit
    drive(1, 12'h100, 32'h0000_00F5, '0, '0, '0); tick("R2");
    drive(1, 12'h100, 32'h0000_0005, '0, '0, '0); tick("R2");
    drive(1, 12'h100, 32'h0, '0, '0, '0);         tick("R2");
    check("R2", "pend value", pending_o, 32'h0000_00F5);

    // R5: lines disabled (enable all zero) still latch
    drive(1, 12'h100, 32'h8000_0000, '0, '0, '0); tick("R5");
    drive(0, 12'h000, 32'h0, 32'h0000_0100, '0, '0); tick("R5");
    check("R5", "pend value", pending_o, 32'h8000_01F5);

    // R3 / R4: clear alias and readback of both aliases
    drive(1, 12'h180, 32'h8000_0005, '0, '0, '0); tick("R3");
    check("R3", "pend value", pending_o, 32'h0000_01F0);
    peek("R4", 12'h180);
    peek("R4", 12'h100);

    // R8: acknowledge line 4 -> pending clears, active sets
    drive(0, 12'h200, 32'h0, '0, 32'h10, '0); tick("R8");
    check("R8", "act value", active_o, 32'h10);
    // R7: re-pend line 4 then software-clear it; active must hold
    drive(1, 12'h100, 32'h10, '0, '0, '0); tick("R7");
    drive(1, 12'h180, 32'h10, '0, '0, '0); tick("R7");
    check("R7", "act kept", active_o, 32'h10);

    // R6: request and software clear on line 5 in one cycle
    drive(1, 12'h180, 32'h20, 32'h20, '0, '0); tick("R6");
    check("R6", "req beats clr", pending_o & 32'h20, 32'h20);
    // R6: request and acknowledge on line 6 in one cycle
    drive(0, 12'h100, 32'h0, 32'h40, 32'h40, '0); tick("R6");
    check("R6", "req beats ack", pending_o & 32'h40, 32'h40);

    // R8: ack and done together on line 7, then done alone on line 4
    drive(0, 12'h100, 32'h0, '0, 32'h80, 32'h80); tick("R8");
    check("R8", "ack beats done", active_o & 32'h80, 32'h80);
    drive(0, 12'h100, 32'h0, '0, '0, 32'h10); tick("R8");
    check("R8", "done clears", active_o & 32'h10, 32'h0);

    // R9: enable set and clear aliases
    drive(1, 12'h000, 32'hFF00_FF00, '0, '0, '0); tick("R9");
    drive(1, 12'h080, 32'h0F00_0000, '0, '0, '0); tick("R9");
    check("R9", "en value", enable_o, 32'hF000_FF00);
    peek("R9", 12'h080);

    // R10: writes to active word ignored
    drive(1, 12'h200, 32'hFFFF_FFFF, '0, '0, '0); tick("R10");

    // R11: unmapped write/read, low address bits ignored
    drive(1, 12'h104, 32'hFFFF_FFFF, '0, '0, '0); tick("R11");
    drive(1, 12'hFFC, 32'hFFFF_FFFF, '0, '0, '0); tick("R11");
    peek("R11", 12'h300);
    drive(1, 12'h182, 32'h0000_0100, '0, '0, '0); tick("R11");
    check("R11", "lsb alias", pending_o & 32'h100, 32'h0);

    // Random phase: all requirements under mixed traffic
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] a;
      logic [2:0]  pick;
      pick = 3'($urandom_range(0, 7));
      case (pick)
        3'd0: a = 12'h000;
        3'd1: a = 12'h080;
        3'd2: a = 12'h100;
        3'd3: a = 12'h180;
        3'd4: a = 12'h200;
        3'd5: a = 12'h100 | 12'($urandom_range(0, 3));
        default: a = 12'($urandom_range(0, 4095));
      endcase
      drive(1'($urandom_range(0, 1)), a, $urandom(),
            $urandom() & $urandom() & $urandom(),
            $urandom() & $urandom() & $urandom(),
            $urandom() & $urandom());
      tick("R6");
    end

    drive(0, 12'h0, 32'h0, '0, '0, '0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule